// File: doc/BRIEF.md
# Linear Sensor Scan Sequencer

This block is the digital timing core of one chip in a linear photodiode array. Every decision it makes is taken on a falling edge of the sensor clock. A negative-going line reset pulse from the host controls the block. While that line is high, the block opens and closes an integration window at fixed edge counts. When the line falls, the block waits a fixed number of edges and then walks a one-hot pixel select across all N elements. It spends four clock periods on each element, gives one sampling strobe in each of those four-clock slots, and drives an active-low end-of-scan output for as long as the last element is selected.

Several chips can share the clock and the reset line. A chip set up as a master starts its scan from the reset line. A chip set up as a slave ignores the reset fall for readout purposes. It starts instead from the end-of-scan output of the chip before it, and places its first element in the slot directly after that chip's last element, so a chain of chips forms one stream with no gap. The photodiodes, amplifiers and video path are not modelled. A pixel index output stands in for them.

Top module: `lin_scan_seq`

## Requirements
- R1: After power-on reset the outputs are at idle: `pix_idx` = N, `pix_sel` = 0, `trig` = 0, `eos_n` = 1, `integ_on` = 0, `proto_err` = 0.
- R2: In master mode (`master_sel` = 1), call the first falling clock edge that samples `line_rst_n` low (after it was high) edge 1. Element 0 is presented from edge 19 onward. Each element is held for 4 edges, and then the index advances by one. While element k is presented, `pix_idx` = k and `pix_sel` has only bit k set.
- R3: `trig` goes high at the 2nd falling edge of each 4-edge element slot and low again at the 3rd, so it is high for exactly one clock per element.
- R4: `eos_n` is low for exactly the 4 edges of element N-1 and high at all other times.
- R5: `integ_on` rises at the 8th falling edge of an unbroken high run of `line_rst_n` (the edge that first samples it high counts as 1). It falls at the 7th falling edge of an unbroken low run.
- R6: In slave mode (`master_sel` = 0), element 0 starts 3 edges after the first edge that samples `ext_start_n` low (after high). A fall of `line_rst_n` starts no readout in slave mode, and `ext_start_n` starts none in master mode.
- R7: When a slave's `ext_start_n` is fed by a master's `eos_n`, the slave presents element 0 on the same edge at which the master returns to idle.
- R8: A rise of `line_rst_n` seen while a scan is pending or running does not stop the scan. It sets `proto_err`, which stays 1 until power-on reset.
- R9: A start condition seen while a scan is pending or running is ignored. The running scan continues unchanged.
- R10: Between scans the outputs return to the idle values of R1 (except `integ_on` and `proto_err`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sensor clock; all state changes on its falling edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| line_rst_n | input | 1 | Host reset line, negative-going pulse; high = integrate |
| ext_start_n | input | 1 | Start from the preceding chip's end-of-scan, active low |
| master_sel | input | 1 | 1 = master (start from reset line), 0 = slave |
| pix_idx | output | $clog2(N_PIX+1) | Index of the element being presented; N_PIX when idle |
| pix_sel | output | N_PIX | One-hot element select; zero when idle |
| trig | output | 1 | Sampling strobe, one clock per element slot |
| eos_n | output | 1 | End of scan, low during the last element |
| integ_on | output | 1 | High while the integration window is open |
| proto_err | output | 1 | Sticky flag: reset line rose during a scan |

## Verification
The bound assertions check, on every edge, the properties that hold from one cycle to the next: the select is at most one-hot, the idle values hold whenever no scan runs, the strobe is a single-cycle pulse, end-of-scan occurs only on the last element, the index advances at each slot boundary, and the error flag is sticky. The exact edge counts need a scenario with a known history: the 19-edge latency after the reset fall, the 3-edge slave lead, the 8- and 7-edge integration bounds, gapless chaining and ignored restarts. Only the bench's edge-by-edge reference model, run over the parallel, interrupted and chained scenarios, can check these.

// File: rtl/lin_scan_pkg.sv
package lin_scan_pkg;

  // Line events decoded on one falling clock edge
  typedef struct packed {
    logic level;     // current level of the reset line
    logic rise;      // line seen high after low
    logic fall;      // line seen low after high
    logic ext_fall;  // external start seen low after high
  } line_ev_t;

  // Edges between master start detection (edge 1) and the first element
  function automatic int master_lead(input int first_edge);
    return first_edge - 1;
  endfunction

  // Edges between slave start detection and the first element:
  // detection lags the predecessor's last slot by one edge
  function automatic int slave_lead(input int slot_clks);
    return slot_clks - 1;
  endfunction

  function automatic int larger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lss_line_sampler.sv
module lss_line_sampler
  import lin_scan_pkg::*;
(
  input  logic     clk,
  input  logic     por_n,
  input  logic     line_rst_n,
  input  logic     ext_start_n,
  output line_ev_t ev
);

  logic rst_q;
  logic ext_q;

  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_q <= 1'b1;
      ext_q <= 1'b1;
    end else begin
      rst_q <= line_rst_n;
      ext_q <= ext_start_n;
    end
  end

  always_comb begin
    ev.level    = line_rst_n;
    ev.rise     = !rst_q && line_rst_n;
    ev.fall     = rst_q && !line_rst_n;
    ev.ext_fall = ext_q && !ext_start_n;
  end

endmodule

// File: rtl/lss_integ_timer.sv
module lss_integ_timer
  import lin_scan_pkg::*;
#(
  parameter int OPEN_EDGE  = 8,
  parameter int CLOSE_EDGE = 7
) (
  input  logic     clk,
  input  logic     por_n,
  input  line_ev_t ev,
  output logic     integ_on
);

  localparam int CMAX = larger(OPEN_EDGE, CLOSE_EDGE);
  localparam int CW   = $clog2(CMAX + 1);

  // Length of the current constant run of the reset line, saturating
  logic [CW-1:0] run_len;

  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) begin
      run_len  <= CW'(CMAX);
      integ_on <= 1'b0;
    end else begin
      if (ev.rise || ev.fall)
        run_len <= CW'(1);
      else if (run_len != CW'(CMAX))
        run_len <= run_len + CW'(1);

      if (ev.level && !ev.rise && run_len == CW'(OPEN_EDGE - 1))
        integ_on <= 1'b1;
      else if (!ev.level && !ev.fall && run_len == CW'(CLOSE_EDGE - 1))
        integ_on <= 1'b0;
    end
  end

endmodule

// File: rtl/lss_launch.sv
module lss_launch
  import lin_scan_pkg::*;
#(
  parameter int FIRST_EDGE = 19,
  parameter int SLOT_CLKS  = 4
) (
  input  logic     clk,
  input  logic     por_n,
  input  line_ev_t ev,
  input  logic     master_sel,
  input  logic     scan_busy,
  output logic     lead_on,
  output logic     launch
);

  localparam int LEAD_M = master_lead(FIRST_EDGE);
  localparam int LEAD_S = slave_lead(SLOT_CLKS);
  localparam int LW     = $clog2(larger(LEAD_M, LEAD_S) + 1);

  logic [LW-1:0] lead_cnt;
  logic          fire;

  assign fire   = master_sel ? ev.fall : ev.ext_fall;
  assign launch = lead_on && (lead_cnt == LW'(1));

  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) begin
      lead_on  <= 1'b0;
      lead_cnt <= '0;
    end else if (lead_on) begin
      lead_cnt <= lead_cnt - LW'(1);
      if (launch) lead_on <= 1'b0;
    end else if (fire && !scan_busy) begin
      lead_on  <= 1'b1;
      lead_cnt <= master_sel ? LW'(LEAD_M) : LW'(LEAD_S);
    end
  end

endmodule

// File: rtl/lss_pixel_stepper.sv
module lss_pixel_stepper #(
  parameter int N_PIX     = 32,
  parameter int SLOT_CLKS = 4,
  localparam int PW = $clog2(N_PIX),
  localparam int HW = $clog2(SLOT_CLKS)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          launch,
  output logic          busy,
  output logic [PW-1:0] pix,
  output logic [HW-1:0] phase,
  output logic          slot_end,
  output logic          last
);

  assign slot_end = busy && (phase == HW'(SLOT_CLKS - 1));
  assign last     = busy && (pix == PW'(N_PIX - 1));

  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) begin
      busy  <= 1'b0;
      pix   <= '0;
      phase <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      pix   <= '0;
      phase <= '0;
    end else if (busy) begin
      if (slot_end) begin
        phase <= '0;
        if (last) busy <= 1'b0;
        else      pix  <= pix + PW'(1);
      end else begin
        phase <= phase + HW'(1);
      end
    end
  end

endmodule

// File: rtl/lin_scan_seq.sv
module lin_scan_seq
  import lin_scan_pkg::*;
#(
  parameter int N_PIX          = 32,
  parameter int FIRST_EDGE     = 19,
  parameter int SLOT_CLKS      = 4,
  parameter int TRIG_PHASE     = 1,
  parameter int INT_OPEN_EDGE  = 8,
  parameter int INT_CLOSE_EDGE = 7,
  localparam int IDX_W = $clog2(N_PIX + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             line_rst_n,
  input  logic             ext_start_n,
  input  logic             master_sel,
  output logic [IDX_W-1:0] pix_idx,
  output logic [N_PIX-1:0] pix_sel,
  output logic             trig,
  output logic             eos_n,
  output logic             integ_on,
  output logic             proto_err
);

  localparam int PW = $clog2(N_PIX);
  localparam int HW = $clog2(SLOT_CLKS);

  line_ev_t      ev;
  logic          busy;
  logic          lead_on;
  logic          launch;
  logic          slot_end;
  logic          last;
  logic [PW-1:0] pix;
  logic [HW-1:0] phase;

  lss_line_sampler u_sampler (
    .clk(clk), .por_n(por_n), .line_rst_n(line_rst_n),
    .ext_start_n(ext_start_n), .ev(ev)
  );

  lss_integ_timer #(.OPEN_EDGE(INT_OPEN_EDGE), .CLOSE_EDGE(INT_CLOSE_EDGE)) u_integ (
    .clk(clk), .por_n(por_n), .ev(ev), .integ_on(integ_on)
  );

  lss_launch #(.FIRST_EDGE(FIRST_EDGE), .SLOT_CLKS(SLOT_CLKS)) u_launch (
    .clk(clk), .por_n(por_n), .ev(ev), .master_sel(master_sel),
    .scan_busy(busy), .lead_on(lead_on), .launch(launch)
  );

  lss_pixel_stepper #(.N_PIX(N_PIX), .SLOT_CLKS(SLOT_CLKS)) u_step (
    .clk(clk), .por_n(por_n), .launch(launch), .busy(busy),
    .pix(pix), .phase(phase), .slot_end(slot_end), .last(last)
  );

  // Sticky error: reset line rose while a scan was pending or running
  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n)                        proto_err <= 1'b0;
    else if (ev.rise && (busy || lead_on)) proto_err <= 1'b1;
  end

  assign pix_idx = busy ? IDX_W'(pix) : IDX_W'(N_PIX);
  assign trig    = busy && (phase == HW'(TRIG_PHASE));
  assign eos_n   = !last;

  for (genvar g = 0; g < N_PIX; g++) begin : g_sel
    assign pix_sel[g] = busy && (pix == PW'(g));
  end

endmodule

// File: rtl/lin_scan_seq_chk.sv
module lin_scan_seq_chk #(
  parameter int N_PIX = 32,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             por_n,
  input logic [IDX_W-1:0] pix_idx,
  input logic [N_PIX-1:0] pix_sel,
  input logic             trig,
  input logic             eos_n,
  input logic             proto_err,
  input logic             busy,
  input logic             slot_end,
  input logic             lead_on
);

  a_r2_onehot_sel: assert property (@(negedge clk) disable iff (!por_n)
    $onehot0(pix_sel));

  a_r2_advance: assert property (@(negedge clk) disable iff (!por_n)
    (slot_end && eos_n) |=> (pix_idx == $past(pix_idx) + IDX_W'(1)));

  a_r10_idle: assert property (@(negedge clk) disable iff (!por_n)
    !busy |-> (pix_idx == IDX_W'(N_PIX) && pix_sel == '0 && !trig && eos_n));

  a_r3_trig_single: assert property (@(negedge clk) disable iff (!por_n)
    trig |=> !trig);

  a_r4_eos_last: assert property (@(negedge clk) disable iff (!por_n)
    !eos_n |-> (pix_idx == IDX_W'(N_PIX - 1)));

  a_r8_sticky: assert property (@(negedge clk) disable iff (!por_n)
    proto_err |=> proto_err);

  a_r8_cause: assert property (@(negedge clk) disable iff (!por_n)
    $rose(proto_err) |-> $past(busy || lead_on));

endmodule

bind lin_scan_seq lin_scan_seq_chk #(.N_PIX(N_PIX), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .por_n(por_n), .pix_idx(pix_idx), .pix_sel(pix_sel),
  .trig(trig), .eos_n(eos_n), .proto_err(proto_err), .busy(busy),
  .slot_end(slot_end), .lead_on(lead_on)
);

// File: tb/lin_scan_seq_bench.sv
module lin_scan_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 32;
  localparam int IW         = $clog2(NP + 1);
  localparam int FIRST      = 19;   // R2 latency in edges
  localparam int SLOT       = 4;    // edges per element
  localparam int SLAVE_GAP  = 3;    // R6 lead in edges

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic line_n = 1'b1;
  logic ext_a = 1'b1;
  logic ext_b = 1'b1;
  logic ms_b = 1'b1;
  logic chain_en = 1'b0;
  logic ext_b_eff;

  logic [IW-1:0] a_idx, b_idx;
  logic [NP-1:0] a_sel, b_sel;
  logic a_trig, b_trig, a_eos_n, b_eos_n, a_integ, b_integ, a_err, b_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ext_b_eff = chain_en ? a_eos_n : ext_b;

  lin_scan_seq #(.N_PIX(NP)) u_lin_scan_seq (
    .clk(clk), .por_n(por_n), .line_rst_n(line_n), .ext_start_n(ext_a),
    .master_sel(1'b1), .pix_idx(a_idx), .pix_sel(a_sel), .trig(a_trig),
    .eos_n(a_eos_n), .integ_on(a_integ), .proto_err(a_err)
  );

  lin_scan_seq #(.N_PIX(NP)) u_lin_scan_seq_b (
    .clk(clk), .por_n(por_n), .line_rst_n(line_n), .ext_start_n(ext_b_eff),
    .master_sel(ms_b), .pix_idx(b_idx), .pix_sel(b_sel), .trig(b_trig),
    .eos_n(b_eos_n), .integ_on(b_integ), .proto_err(b_err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model: edge numbers and event times per chip
  int m_k[2], m_run[2], m_start[2], e_idx[2];
  bit m_valid[2], m_integ[2], m_err[2], m_prst[2], m_pext[2];
  bit e_trig[2], e_eos_n[2];

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_k[i] = 0; m_run[i] = 1000; m_start[i] = 0; m_valid[i] = 0;
      m_integ[i] = 0; m_err[i] = 0; m_prst[i] = 1; m_pext[i] = 1;
      e_idx[i] = NP; e_trig[i] = 0; e_eos_n[i] = 1;
    end
  end

  task automatic model_edge(input int i, input logic rst, input logic ext, input logic ms);
    bit act, rise, fall, efall;
    int off;
    m_k[i]++;
    act   = m_valid[i] && (m_k[i] - 1 <= m_start[i] + SLOT*NP - 1);
    rise  = !m_prst[i] && rst;
    fall  = m_prst[i] && !rst;
    efall = m_pext[i] && !ext;
    if (rise && act) m_err[i] = 1;
    if (!act) begin
      m_valid[i] = 0;
      if (ms && fall) begin
        m_valid[i] = 1; m_start[i] = m_k[i] + FIRST - 1;
      end else if (!ms && efall) begin
        m_valid[i] = 1; m_start[i] = m_k[i] + SLAVE_GAP;
      end
    end
    if (rise || fall) m_run[i] = 1;
    else if (m_run[i] < 1000) m_run[i]++;
    if (rst && m_run[i] == 8) m_integ[i] = 1;
    if (!rst && m_run[i] == 7) m_integ[i] = 0;
    if (m_valid[i] && m_k[i] >= m_start[i] && m_k[i] < m_start[i] + SLOT*NP) begin
      off = m_k[i] - m_start[i];
      e_idx[i] = off / SLOT;
      e_trig[i] = (off % SLOT) == 1;
      e_eos_n[i] = (off / SLOT) != NP - 1;
    end else begin
      e_idx[i] = NP; e_trig[i] = 0; e_eos_n[i] = 1;
    end
    m_prst[i] = rst;
    m_pext[i] = ext;
  endtask

  always @(negedge clk) begin
    if (por_n) begin
      model_edge(0, line_n, ext_a, 1'b1);
      model_edge(1, line_n, ext_b_eff, ms_b);
    end
  end

  function automatic logic [NP-1:0] onehot_of(input int idx);
    logic [NP-1:0] v = '0;
    if (idx < NP) v[idx] = 1'b1;
    return v;
  endfunction

  int prev_a_idx = NP;

  // Compare both chips with the model on every rising edge (mid-cycle)
  always @(posedge clk) begin
    if (!done) begin
      chk(a_idx == IW'(e_idx[0]), "R2,R9", "A idx", a_idx, e_idx[0]);
      chk(a_sel == onehot_of(e_idx[0]), "R2", "A sel", a_sel, onehot_of(e_idx[0]));
      chk(a_trig == e_trig[0], "R3", "A trig", a_trig, e_trig[0]);
      chk(a_eos_n == e_eos_n[0], "R4", "A eos_n", a_eos_n, e_eos_n[0]);
      chk(a_integ == m_integ[0], "R5", "A integ", a_integ, m_integ[0]);
      chk(a_err == m_err[0], "R8", "A err", a_err, m_err[0]);
      chk(b_idx == IW'(e_idx[1]), "R6,R9", "B idx", b_idx, e_idx[1]);
      chk(b_sel == onehot_of(e_idx[1]), "R6", "B sel", b_sel, onehot_of(e_idx[1]));
      chk(b_trig == e_trig[1], "R3", "B trig", b_trig, e_trig[1]);
      chk(b_eos_n == e_eos_n[1], "R4", "B eos_n", b_eos_n, e_eos_n[1]);
      chk(b_integ == m_integ[1], "R5", "B integ", b_integ, m_integ[1]);
      chk(b_err == m_err[1], "R8", "B err", b_err, m_err[1]);
      if (chain_en && prev_a_idx == NP - 1 && a_idx == IW'(NP))
        chk(b_idx == IW'(0), "R7", "B idx at handover", b_idx, 0);
      prev_a_idx = a_idx;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    wait_clk(4);
    // R1: idle values under power-on reset
    chk(a_idx == IW'(NP) && b_idx == IW'(NP), "R1", "idx", a_idx, NP);
    chk(a_sel == '0 && !a_trig && a_eos_n, "R1", "sel/trig/eos", a_sel, 0);
    chk(!a_integ && !a_err && !b_integ && !b_err, "R1", "integ/err", a_err, 0);
    por_n = 1'b1;

    // Parallel scan: both chips master; external start toggled on A (R6)
    wait_clk(30);
    line_n = 1'b0; wait_clk(14);
    line_n = 1'b1; wait_clk(8);
    ext_a = 1'b0;  wait_clk(3);
    ext_a = 1'b1;  wait_clk(150);
    chk(a_idx == IW'(NP) && b_idx == IW'(NP), "R10", "idle idx", a_idx, NP);
    chk(a_sel == '0 && b_sel == '0 && a_eos_n, "R10", "idle sel", a_sel, 0);

    // Fall during readout ignored (R9), rise during readout flags (R8)
    line_n = 1'b0; wait_clk(14);
    line_n = 1'b1; wait_clk(50);
    chk(a_idx != IW'(NP), "R9", "scan running", a_idx, 1);
    line_n = 1'b0; wait_clk(14);
    line_n = 1'b1; wait_clk(120);
    chk(a_err && b_err, "R8", "sticky err", a_err, 1);

    // Chained scan: B is a slave driven by A's end-of-scan (R6, R7)
    ms_b = 1'b0;
    chain_en = 1'b1;
    wait_clk(20);
    line_n = 1'b0; wait_clk(14);
    line_n = 1'b1; wait_clk(300);
    chk(b_idx == IW'(NP) && a_err, "R10", "chain done idle", b_idx, NP);
    finish_run();
  end

endmodule